// File: doc/BRIEF.md
# Enabled One-Bit-Step Six-State Sequence Generator

This block is a small clocked state machine with one enable bit and a three-bit output. On every rising clock edge where the enable is high, the output moves one position along a fixed cycle of six codes: 000, 001, 011, 111, 110, 100, and then back to 000. On edges where the enable is low, the output holds its value. Neighbouring codes in the cycle differ in exactly one bit. Downstream logic that samples the value across clock domains, or that counts switching activity, therefore sees a single transition per step.

The output is the state register itself (Moore style), with no decode after the flops. The next state is formed as a per-bit toggle mask XORed into the register, which is the same as a bank of toggle flip-flops. The two codes outside the cycle, 010 and 101, are never entered in normal operation. If one appears, the next edge clears the register to 000 whatever the enable is. A parameter sets the value loaded by reset. It defaults to 000.

Output bit 2 carries the most significant bit of the sequence value (the first of the three outputs), and bit 0 carries the least.

Top module: `gray_cycle_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `seqCode` takes the value of parameter `RESET_CODE` (default 3'b000) after that edge, regardless of `advance`.
- R2: At a rising edge with `rst` low, `advance` low and `seqCode` holding one of the six cycle codes, `seqCode` keeps its value.
- R3: At a rising edge with `rst` low and `advance` high, `seqCode` moves to the next code of the cycle 000 → 001 → 011 → 111 → 110 → 100 → 000 (written as 3-bit binary, bit 2 first).
- R4: Every step taken under R3 changes exactly one bit of `seqCode`.
- R5: At a rising edge with `rst` low and `seqCode` equal to 3'b010 or 3'b101, `seqCode` becomes 3'b000 after that edge, whether `advance` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Enable: step the cycle when high, hold when low |
| seqCode | output | 3 | Present state code, driven straight from the state register |

## Verification
The bench builds the default instance with `RESET_CODE` = 000 to walk the cycle under directed and random enable patterns. It also builds two more instances with `RESET_CODE` set to 3'b010 and 3'b101. These two reset values are the only way the port-level stimulus can place the register in an unused code. They make R5 observable from outside, with the enable both low and high on the recovery edge.

// File: rtl/gray_cycle_pkg.sv
package gray_cycle_pkg;

  localparam int CODE_W   = 3;
  localparam int CYCLE_LEN = 2 * CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  // Strobes from control to datapath.
  typedef struct packed {
    code_t toggleMask;  // bits to flip on this edge
    logic  clearAll;    // force the register to zero (recovery)
  } strobe_t;

  // Code with the lowest k bits set.
  function automatic code_t lowFill(input int k);
    code_t v;
    v = '0;
    for (int j = 0; j < CODE_W; j++) begin
      if (j < k) v[j] = 1'b1;
    end
    return v;
  endfunction

  // Code held at position r of the cycle.
  function automatic code_t codeAt(input int r);
    if (r < CODE_W) return lowFill(r);
    return ~lowFill(r - CODE_W);
  endfunction

  function automatic logic isValid(input code_t c);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < CYCLE_LEN; r++) begin
      if (codeAt(r) == c) hit = 1'b1;
    end
    return hit;
  endfunction

  // Successor in the cycle, by position lookup.
  function automatic code_t stepOf(input code_t c);
    code_t n;
    n = '0;
    for (int r = 0; r < CYCLE_LEN; r++) begin
      if (codeAt(r) == c) n = codeAt((r + 1) % CYCLE_LEN);
    end
    return n;
  endfunction

endpackage

// File: rtl/gray_cycle_ctrl.sv
module gray_cycle_ctrl
  import gray_cycle_pkg::*;
(
  input  code_t   curCode,
  input  logic    advance,
  output strobe_t strobes
);

  logic [CODE_W-1:0] flipHere;
  logic [CODE_W-1:0] legalHit;

  // Bit i flips when leaving the low-filled code with i ones,
  // or its complement.
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    code_t trigLow;
    assign trigLow     = lowFill(i);
    assign flipHere[i] = (curCode == trigLow) || (curCode == ~trigLow);
    assign legalHit[i] = flipHere[i];
  end

  logic inCycle;
  assign inCycle = |legalHit;

  always_comb begin
    strobes.clearAll   = ~inCycle;
    strobes.toggleMask = (advance && inCycle) ? flipHere : '0;
  end

endmodule

// File: rtl/gray_cycle_dp.sv
module gray_cycle_dp
  import gray_cycle_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobes,
  output code_t   stateQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= RESET_CODE;
    end else if (strobes.clearAll) begin
      stateQ <= '0;
    end else begin
      stateQ <= stateQ ^ strobes.toggleMask;
    end
  end

endmodule

// File: rtl/gray_cycle_gen.sv
module gray_cycle_gen
  import gray_cycle_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [CODE_W-1:0] seqCode
);

  strobe_t strobes;
  code_t   stateQ;

  gray_cycle_ctrl u_ctrl (
    .curCode (stateQ),
    .advance (advance),
    .strobes (strobes)
  );

  gray_cycle_dp #(.RESET_CODE(RESET_CODE)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  assign seqCode = stateQ;

endmodule

// File: rtl/gray_cycle_chk.sv
module gray_cycle_chk
  import gray_cycle_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic [CODE_W-1:0] seqCode
);

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> seqCode == RESET_CODE);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && isValid(seqCode)) |=> $stable(seqCode));

  a_r3_next_code: assert property (@(posedge clk) disable iff (rst)
    (advance && isValid(seqCode)) |=> seqCode == stepOf($past(seqCode)));

  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    (advance && isValid(seqCode)) |=> $countones(seqCode ^ $past(seqCode)) == 1);

  a_r5_recover: assert property (@(posedge clk) disable iff (rst)
    (!isValid(seqCode) && !$isunknown(seqCode)) |=> seqCode == '0);

endmodule

bind gray_cycle_gen gray_cycle_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .advance (advance),
  .seqCode (seqCode)
);

// File: tb/gray_cycle_gen_bench.sv
`timescale 1ns/1ps
module gray_cycle_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       advance = 1'b0;
  logic [2:0] seqCode, altA, altB;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gray_cycle_gen u_gray_cycle_gen (.clk(clk), .rst(rst), .advance(advance), .seqCode(seqCode));
  gray_cycle_gen #(.RESET_CODE(3'b010)) uAltA (.clk(clk), .rst(rst), .advance(advance), .seqCode(altA));
  gray_cycle_gen #(.RESET_CODE(3'b101)) uAltB (.clk(clk), .rst(rst), .advance(advance), .seqCode(altB));

  // Reference cycle, written from the requirement text.
  localparam logic [2:0] REF_SEQ [6] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b100};

  // {advance, expected seqCode after the edge}, starting from 000.
  localparam logic [3:0] VEC [16] = '{
    4'b1_001, 4'b0_001, 4'b1_011, 4'b1_111, 4'b0_111, 4'b1_110, 4'b1_100, 4'b0_100,
    4'b1_000, 4'b1_001, 4'b1_011, 4'b1_111, 4'b1_110, 4'b1_100, 4'b1_000, 4'b0_000
  };

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic tick(input logic adv);
    advance = adv;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    tick(1'b1);
    // R1: reset value on every instance, even with advance high
    check("R1", seqCode, 3'b000);
    check("R1", altA, 3'b010);
    check("R1", altB, 3'b101);
    rst = 1'b0;

    // R5: unused codes clear with advance low
    tick(1'b0);
    check("R5", altA, 3'b000);
    check("R5", altB, 3'b000);
    check("R2", seqCode, 3'b000);

    // Table walk (R2 for holds, R3 for steps, R4 single-bit change)
    for (int i = 0; i < 16; i++) begin
      logic [2:0] prev;
      prev = seqCode;
      tick(VEC[i][3]);
      check(VEC[i][3] ? "R3" : "R2", seqCode, VEC[i][2:0]);
      if (VEC[i][3]) check("R4", 3'($countones(prev ^ seqCode)), 3'd1);
    end

    // Random enable pattern against the reference model
    begin
      int idx;
      idx = 0;
      for (int c = 0; c < 120; c++) begin
        logic       adv;
        logic [2:0] prev;
        adv  = 1'($urandom_range(0, 1));
        prev = seqCode;
        tick(adv);
        if (adv) idx = (idx + 1) % 6;
        check(adv ? "R3" : "R2", seqCode, REF_SEQ[idx]);
        if (adv) check("R4", 3'($countones(prev ^ seqCode)), 3'd1);
      end
    end

    // R1: reset in mid-cycle
    tick(1'b1);
    tick(1'b1);
    rst = 1'b1;
    tick(1'b1);
    check("R1", seqCode, 3'b000);
    check("R1", altA, 3'b010);
    rst = 1'b0;

    // R5: unused codes clear with advance high, not stepping on
    tick(1'b1);
    check("R5", altA, 3'b000);
    check("R5", altB, 3'b000);
    check("R3", seqCode, 3'b001);

    finishRun();
  end

endmodule